// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a mobile SDRAM from reset to a usable state. Once reset is released it holds clock enable high and places no-operation commands on the command bus for a programmable stable-clock interval. It then closes all banks, runs a programmable number of auto-refresh cycles, and loads the normal mode register and then the extended mode register from static configuration inputs. When the last mode-register write has settled, it raises a done flag and leaves the bus idle so that the normal memory controller can take over.

Every wait is a parameter in clock cycles: the power-up interval, the precharge recovery and the refresh cycle time. The gap that follows a mode-register write is fixed at two clocks. One shared down-counter times every wait. The command lines are decoded straight from the state register. Each command is held for exactly one cycle.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and for the first PWRUP_CYC cycles after its release (cycles 0 to PWRUP_CYC-1, where cycle 0 is the cycle in which reset goes high), cke_o is 1, the command is NOP ({cs_n,ras_n,cas_n,we_n}=0111), and init_done_o is 0.
- R2: In cycle PWRUP_CYC the sequencer issues precharge-all: command 0010, addr_o bit 10 = 1, all other address bits 0, ba_o = 00.
- R3: The first auto-refresh comes exactly RP_CYC cycles after the precharge, with NOPs in between.
- R4: Exactly N_REF auto-refresh commands (command 0001, address 0, bank 0) are issued, RC_CYC cycles apart, with NOPs in between.
- R5: RC_CYC cycles after the last refresh, a normal mode-register write is issued: command 0000, ba_o = 00, addr_o[2:0] = burst length, bit 3 = burst type, bits 6:4 = CAS latency, bit 9 = single-write mode, and all other bits 0.
- R6: Two cycles after the normal write, an extended mode-register write is issued: command 0000, ba_o = 10, addr_o[2:0] = refresh-array size, bits 6:5 = drive strength, and all other bits 0.
- R7: After each mode-register write the next cycle carries NOP. init_done_o rises two cycles after the extended write, then stays high with NOP on the bus until reset.
- R8: Every non-NOP command lasts exactly one cycle.
- R9: A reset asserted in the middle of the sequence returns the bus to NOP with init_done_o low at once, and the whole sequence then restarts from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| burst_len_i | input | 3 | Burst-length code for the normal mode register |
| burst_type_i | input | 1 | Burst ordering (0 sequential, 1 interleaved) |
| cas_lat_i | input | 3 | CAS-latency code |
| wr_single_i | input | 1 | Single-location write mode select |
| pasr_i | input | 3 | Refresh-array size code (000 full, 001 half, 010 quarter) |
| drv_str_i | input | 2 | Output drive-strength code |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | ADDR_W | Address lines |
| init_done_o | output | 1 | Initialization finished |

## Verification
The hardest case to reach from the ports is a reset that arrives part-way through the refresh train. At that point the refresh counter and the shared timer both hold values other than their reset values. The stimulus runs a full sequence until the second refresh interval, pulls reset low between clock edges, and checks that the bus drops to NOP at once. It then replays the complete cycle-exact walk with a different configuration. A leftover refresh count or timer value would show up as a shifted or missing command.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  localparam logic [1:0] BA_MODE = 2'b00;
  localparam logic [1:0] BA_EXT  = 2'b10;

  localparam int MRD_CYC = 2;

  typedef enum logic [3:0] {
    ST_WAIT_PWR,
    ST_PRE,
    ST_WAIT_RP,
    ST_REF,
    ST_WAIT_RC,
    ST_MRS,
    ST_WAIT_MRD,
    ST_EMRS,
    ST_WAIT_EMRD,
    ST_DONE
  } init_state_e;
endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_init_mode.sv
module sdram_init_mode #(
  parameter int ADDR_W = 13
) (
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              wr_single_i,
  input  logic [2:0]        pasr_i,
  input  logic [1:0]        drv_str_i,
  output logic [ADDR_W-1:0] mrs_word_o,
  output logic [ADDR_W-1:0] emrs_word_o
);
  always_comb begin
    mrs_word_o      = '0;
    mrs_word_o[2:0] = burst_len_i;
    mrs_word_o[3]   = burst_type_i;
    mrs_word_o[6:4] = cas_lat_i;
    mrs_word_o[9]   = wr_single_i;

    emrs_word_o      = '0;
    emrs_word_o[2:0] = pasr_i;
    emrs_word_o[6:5] = drv_str_i;
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int PWRUP_CYC = 25000,
  parameter int RP_CYC    = 3,
  parameter int RC_CYC    = 9,
  parameter int N_REF     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        burst_len_i,
  input  logic              burst_type_i,
  input  logic [2:0]        cas_lat_i,
  input  logic              wr_single_i,
  input  logic [2:0]        pasr_i,
  input  logic [1:0]        drv_str_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o
);
  localparam int W_A      = (PWRUP_CYC - 1 > RC_CYC - 2) ? PWRUP_CYC - 1 : RC_CYC - 2;
  localparam int MAX_WAIT = (W_A > RP_CYC - 2) ? W_A : RP_CYC - 2;
  localparam int CNT_W    = (MAX_WAIT < 1) ? 1 : $clog2(MAX_WAIT + 1);
  localparam int REF_W    = $clog2(N_REF + 1);

  init_state_e       state_q, state_d;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic [REF_W-1:0]  ref_cnt_q;
  logic              ref_inc;
  logic [ADDR_W-1:0] mrs_word, emrs_word;
  logic [3:0]        cmd;

  sdram_init_timer #(.CNT_W(CNT_W), .RST_VAL(PWRUP_CYC - 1)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sdram_init_mode #(.ADDR_W(ADDR_W)) u_mode (
    .burst_len_i  (burst_len_i),
    .burst_type_i (burst_type_i),
    .cas_lat_i    (cas_lat_i),
    .wr_single_i  (wr_single_i),
    .pasr_i       (pasr_i),
    .drv_str_i    (drv_str_i),
    .mrs_word_o   (mrs_word),
    .emrs_word_o  (emrs_word)
  );

  // wait states last (N-1) cycles so the next command lands N cycles after the last
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_inc  = 1'b0;
    unique case (state_q)
      ST_WAIT_PWR:  if (tmr_zero) state_d = ST_PRE;
      ST_PRE: begin
        state_d  = ST_WAIT_RP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RP_CYC - 2);
      end
      ST_WAIT_RP:   if (tmr_zero) state_d = ST_REF;
      ST_REF: begin
        state_d  = ST_WAIT_RC;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RC_CYC - 2);
        ref_inc  = 1'b1;
      end
      ST_WAIT_RC:
        if (tmr_zero) state_d = (ref_cnt_q == REF_W'(N_REF)) ? ST_MRS : ST_REF;
      ST_MRS: begin
        state_d  = ST_WAIT_MRD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(MRD_CYC - 2);
      end
      ST_WAIT_MRD:  if (tmr_zero) state_d = ST_EMRS;
      ST_EMRS: begin
        state_d  = ST_WAIT_EMRD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(MRD_CYC - 2);
      end
      ST_WAIT_EMRD: if (tmr_zero) state_d = ST_DONE;
      ST_DONE:      state_d = ST_DONE;
      default:      state_d = ST_WAIT_PWR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_WAIT_PWR;
      ref_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (ref_inc) ref_cnt_q <= ref_cnt_q + 1'b1;
    end
  end

  always_comb begin
    cmd    = CMD_NOP;
    ba_o   = BA_MODE;
    addr_o = '0;
    unique case (state_q)
      ST_PRE: begin
        cmd        = CMD_PRE;
        addr_o[10] = 1'b1;
      end
      ST_REF:  cmd = CMD_REF;
      ST_MRS: begin
        cmd    = CMD_MRS;
        addr_o = mrs_word;
      end
      ST_EMRS: begin
        cmd    = CMD_MRS;
        ba_o   = BA_EXT;
        addr_o = emrs_word;
      end
      default: cmd = CMD_NOP;
    endcase
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign cke_o       = 1'b1;
  assign init_done_o = (state_q == ST_DONE);
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W = 13,
  parameter int N_REF  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [1:0]        ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              init_done_o
);
  logic [3:0] cmd;
  logic       is_nop, is_pre, is_ref, is_mrs, is_mode, is_ext;
  logic       pre_seen;
  logic [7:0] ref_seen;

  assign cmd     = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign is_nop  = (cmd == 4'b0111);
  assign is_pre  = (cmd == 4'b0010);
  assign is_ref  = (cmd == 4'b0001);
  assign is_mrs  = (cmd == 4'b0000);
  assign is_mode = is_mrs && (ba_o == 2'b00);
  assign is_ext  = is_mrs && (ba_o == 2'b10);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_seen <= 1'b0;
      ref_seen <= '0;
    end else begin
      if (is_pre) pre_seen <= 1'b1;
      if (is_ref) ref_seen <= ref_seen + 1'b1;
    end
  end

  // R1
  r1_quiet_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_seen |-> ((is_nop || is_pre) && !init_done_o));
  // R2
  r2_pre_a10_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> addr_o[10]);
  // R3
  r3_ref_after_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ref |-> pre_seen);
  // R4
  r4_ref_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mode |-> (ref_seen == 8'(N_REF)));
  // R5
  r5_mode_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mode |-> (addr_o[8:7] == 2'b00 && addr_o[ADDR_W-1:10] == '0));
  // R6
  r6_ext_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ext |-> $past(is_mode, 2));
  // R6
  r6_ext_reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ext |-> (addr_o[4:3] == 2'b00 && addr_o[ADDR_W-1:7] == '0));
  // R7
  r7_mrs_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |=> is_nop);
  // R7
  r7_done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  // R7
  r7_done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> is_nop);
  // R8
  r8_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_nop |=> is_nop);
endmodule

bind sdram_init_seq sdram_init_chk #(.ADDR_W(ADDR_W), .N_REF(N_REF)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_n_o      (cs_n_o),
  .ras_n_o     (ras_n_o),
  .cas_n_o     (cas_n_o),
  .we_n_o      (we_n_o),
  .ba_o        (ba_o),
  .addr_o      (addr_o),
  .init_done_o (init_done_o)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;
  localparam int AW   = 13;
  localparam int P    = 300;
  localparam int RP   = 3;
  localparam int RC   = 8;
  localparam int NREF = 3;
  localparam int T_MRS  = P + RP + NREF * RC;
  localparam int T_EMRS = T_MRS + 2;
  localparam int T_DONE = T_EMRS + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    bl = '0, cl = '0, pasr = '0;
  logic          bt = 1'b0, ws = 1'b0;
  logic [1:0]    ds = '0;
  logic          cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0]    ba;
  logic [AW-1:0] addr;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  sdram_init_seq #(.ADDR_W(AW), .PWRUP_CYC(P), .RP_CYC(RP), .RC_CYC(RC), .N_REF(NREF)) dut (
    .clk_i(clk), .rst_ni(rst_n), .burst_len_i(bl), .burst_type_i(bt), .cas_lat_i(cl),
    .wr_single_i(ws), .pasr_i(pasr), .drv_str_i(ds), .cke_o(cke), .cs_n_o(cs_n),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba), .addr_o(addr),
    .init_done_o(done)
  );

  function automatic logic [20:0] pack_obs();
    return {done, cke, cs_n, ras_n, cas_n, we_n, ba, addr};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [20:0] act, input logic [20:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // expected {done,cke,cmd,ba,addr} in cycle c after reset release
  task automatic expect_at(input int c, output logic [20:0] e, output string tag);
    logic [3:0]    cmd = 4'b0111;
    logic [1:0]    eb  = 2'b00;
    logic [AW-1:0] ea  = '0;
    logic          ed  = 1'b0;
    tag = "R4";
    if (c < P) tag = "R1";
    else if (c == P) begin cmd = 4'b0010; ea[10] = 1'b1; tag = "R2"; end
    else if (c == P + 1) tag = "R8";
    else if (c < P + RP) tag = "R3";
    else if (c < T_MRS) begin
      if ((c - (P + RP)) % RC == 0) cmd = 4'b0001;
    end else if (c == T_MRS) begin
      cmd = 4'b0000; ea[2:0] = bl; ea[3] = bt; ea[6:4] = cl; ea[9] = ws; tag = "R5";
    end else if (c == T_EMRS) begin
      cmd = 4'b0000; eb = 2'b10; ea[2:0] = pasr; ea[6:5] = ds; tag = "R6";
    end else begin
      tag = "R7";
      ed  = (c >= T_DONE);
    end
    e = {ed, 1'b1, cmd, eb, ea};
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // releases reset and checks every cycle of the sequence
  task automatic run_full(input string label);
    logic [20:0] e;
    string tag;
    rst_n = 1'b1;
    for (int c = 0; c <= T_DONE + 5; c++) begin
      #1;
      expect_at(c, e, tag);
      check(pack_obs() == e, tag, $sformatf("%s cycle %0d", label, c), pack_obs(), e);
      @(negedge clk);
    end
  endtask

  task automatic test_reset_state();
    apply_reset();
    #1;
    check(pack_obs() == {1'b0, 1'b1, 4'b0111, 2'b00, 13'h0}, "R1", "bus during reset",
          pack_obs(), {1'b0, 1'b1, 4'b0111, 2'b00, 13'h0});
  endtask

  task automatic test_cfg_a();
    bl = 3'b011; bt = 1'b1; cl = 3'b010; ws = 1'b1; pasr = 3'b001; ds = 2'b01;
    apply_reset();
    run_full("cfg_a");
  endtask

  task automatic test_cfg_b();
    bl = 3'b111; bt = 1'b0; cl = 3'b011; ws = 1'b0; pasr = 3'b010; ds = 2'b10;
    apply_reset();
    run_full("cfg_b");
  endtask

  task automatic test_mid_reset();
    bl = 3'b010; bt = 1'b0; cl = 3'b001; ws = 1'b1; pasr = 3'b000; ds = 2'b11;
    apply_reset();
    rst_n = 1'b1;
    repeat (P + RP + RC + 3) @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    check(pack_obs() == {1'b0, 1'b1, 4'b0111, 2'b00, 13'h0}, "R9", "bus right after mid reset",
          pack_obs(), {1'b0, 1'b1, 4'b0111, 2'b00, 13'h0});
    repeat (2) @(negedge clk);
    bl = 3'b001; cl = 3'b011; pasr = 3'b010; ds = 2'b00;
    run_full("R9 restart");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    test_reset_state();
    test_cfg_a();
    test_cfg_b();
    test_mid_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule